// File: doc/BRIEF.md
# Decode-Stage Register File with Write-Back Bypass

This block holds the general-purpose registers of a five-stage pipelined processor and serves the decode stage. It has thirty-two 32-bit entries, two read ports for the source operands and one write port fed by the write-back stage. All storage and all output registers update on the rising clock edge only. No logic uses the falling edge.

Reads are synchronous, in the manner of on-chip block memory. The decode stage presents a read address before a rising edge, and the operand is valid after that edge. A value committed by write-back at the same edge would otherwise miss that read. To prevent this, each read port compares its address with the write-back address. On a match, the port captures the incoming write data instead of the stored entry, so decode never sees a stale operand.

Register zero is hardwired to zero. Forwarding from later stages and stall generation are outside this block.

Top module: `rf_wb_bypass`

## Requirements
- R1: While reset (`rstN` low) is held and after it is released, every register reads as zero, and both read outputs are zero.
- R2: Reads are synchronous. Each read output changes only at a rising edge, to the value selected by the read address sampled at that edge, and then holds until the next edge.
- R3: A write with `wrEn` high is committed at that rising edge to register `wrAddr` and is returned by any later read of that register. A cycle with `wrEn` low changes no register.
- R4: When a read address equals `wrAddr` at an edge where `wrEn` is high and `wrAddr` is nonzero, that port outputs `wrData` after the edge instead of the old stored value. Each port decides this on its own.
- R5: Register 0 (address 5'd0) always reads as zero. A write to it is discarded and never causes a bypass.
- R6: When both read addresses are equal at an edge, both outputs are identical after that edge, including when the value is bypassed.
- R7: The two read ports are independent. Different addresses at the same edge return the contents of their own registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset; clears all registers and outputs |
| rdAddrA | input | 5 | Source operand A register number |
| rdAddrB | input | 5 | Source operand B register number |
| rdDataA | output | 32 | Operand A, valid after the edge that sampled `rdAddrA` |
| rdDataB | output | 32 | Operand B, valid after the edge that sampled `rdAddrB` |
| wrEn | input | 1 | Write-back enable |
| wrAddr | input | 5 | Write-back destination register |
| wrData | input | 32 | Write-back value |

## Verification
A write-back commit and a decode read of the same register can land on one rising edge. This is the case the comparators exist for.

The bench provokes it in three ways:
- both ports read the register being written;
- only one port reads it while the other reads an unrelated entry;
- a write targets register zero while it is read.

It also runs a random stretch with a deliberately small address range, so collisions are frequent. A reference model written from the requirements predicts, for each edge, the operand decode must receive. A scoreboard compares that prediction against the outputs one cycle later.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int RD_PORTS = 2;

  // strobes from the compare/control slice to the storage slice
  typedef struct packed {
    logic                wrCommit;
    logic [RD_PORTS-1:0] bypass;
    logic [RD_PORTS-1:0] zeroRd;
  } rfStrobes_t;
endpackage

// File: rtl/rf_ctrl.sv
module rf_ctrl
  import rf_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic                           wrEn,
  input  logic [ADDR_W-1:0]              wrAddr,
  input  logic [RD_PORTS-1:0][ADDR_W-1:0] rdAddr,
  output rfStrobes_t                     strb
);
  logic wrLive;

  // a write to entry zero is dropped and never forwarded
  assign wrLive        = wrEn && (wrAddr != '0);
  assign strb.wrCommit = wrLive;

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_cmp
    assign strb.zeroRd[p] = (rdAddr[p] == '0);
    assign strb.bypass[p] = wrLive && (rdAddr[p] == wrAddr);
  end
endmodule

// File: rtl/rf_datapath.sv
module rf_datapath
  import rf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32,
  parameter int ADDR_W = 5
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  rfStrobes_t                      strb,
  input  logic [ADDR_W-1:0]               wrAddr,
  input  logic [DATA_W-1:0]               wrData,
  input  logic [RD_PORTS-1:0][ADDR_W-1:0] rdAddr,
  output logic [RD_PORTS-1:0][DATA_W-1:0] rdQ
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (strb.wrCommit) begin
      mem[wrAddr] <= wrData;
    end
  end

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                rdQ[p] <= '0;
      else if (strb.zeroRd[p])  rdQ[p] <= '0;
      else if (strb.bypass[p])  rdQ[p] <= wrData;
      else                      rdQ[p] <= mem[rdAddr[p]];
    end
  end
endmodule

// File: rtl/rf_wb_bypass.sv
module rf_wb_bypass
  import rf_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int REG_COUNT = 32,
  localparam int ADDR_W   = $clog2(REG_COUNT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] rdAddrA,
  input  logic [ADDR_W-1:0] rdAddrB,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData
);
  rfStrobes_t                      strb;
  logic [RD_PORTS-1:0][ADDR_W-1:0] rdAddr;
  logic [RD_PORTS-1:0][DATA_W-1:0] rdQ;

  assign rdAddr = {rdAddrB, rdAddrA};

  rf_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .rdAddr (rdAddr),
    .strb   (strb)
  );

  rf_datapath #(.DATA_W(DATA_W), .DEPTH(REG_COUNT), .ADDR_W(ADDR_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .rdAddr (rdAddr),
    .rdQ    (rdQ)
  );

  assign rdDataA = rdQ[0];
  assign rdDataB = rdQ[1];
endmodule

// File: rtl/rf_wb_bypass_chk.sv
module rf_wb_bypass_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] rdAddrA,
  input logic [ADDR_W-1:0] rdAddrB,
  input logic [DATA_W-1:0] rdDataA,
  input logic [DATA_W-1:0] rdDataB,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData
);
  AST_BYPASS_PORT_A: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr != '0 && rdAddrA == wrAddr) |=> (rdDataA == $past(wrData))); // R4

  AST_BYPASS_PORT_B: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr != '0 && rdAddrB == wrAddr) |=> (rdDataB == $past(wrData))); // R4

  AST_ZERO_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddrA == '0 || rdAddrB == '0) |=>
      ((($past(rdAddrA) != '0) || rdDataA == '0) &&
       (($past(rdAddrB) != '0) || rdDataB == '0))); // R5

  AST_PORTS_AGREE: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddrA == rdAddrB) |=> (rdDataA == rdDataB)); // R6
endmodule

bind rf_wb_bypass rf_wb_bypass_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk (
  .clk     (clk),
  .rstN    (rstN),
  .rdAddrA (rdAddrA),
  .rdAddrB (rdAddrB),
  .rdDataA (rdDataA),
  .rdDataB (rdDataB),
  .wrEn    (wrEn),
  .wrAddr  (wrAddr),
  .wrData  (wrData)
);

// File: tb/rf_wb_bypass_test.sv
`timescale 1ns/1ps
module rf_wb_bypass_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  rdAddrA = '0, rdAddrB = '0, wrAddr = '0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdDataA, rdDataB;

  always #2.5 clk = ~clk;

  rf_wb_bypass uut (
    .clk(clk), .rstN(rstN),
    .rdAddrA(rdAddrA), .rdAddrB(rdAddrB),
    .rdDataA(rdDataA), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData)
  );

  typedef struct {
    logic [31:0] expA;
    logic [31:0] expB;
    string       req;
  } item_t;

  item_t       sbq[$];
  logic [31:0] model [32];
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] predict(input logic [4:0] a, input logic we,
                                          input logic [4:0] wa, input logic [31:0] wd);
    if (a == 5'd0) return 32'h0;
    if (we && wa == a) return wd;
    return model[a];
  endfunction

  // driver: applies one cycle of stimulus and queues the expected operands
  task automatic drive(input logic [4:0] aA, input logic [4:0] aB, input logic we,
                       input logic [4:0] wa, input logic [31:0] wd, input string req);
    item_t it;
    @(negedge clk);
    rdAddrA = aA; rdAddrB = aB; wrEn = we; wrAddr = wa; wrData = wd;
    it.expA = predict(aA, we, wa, wd);
    it.expB = predict(aB, we, wa, wd);
    it.req  = req;
    if (we && wa != 5'd0) model[wa] = wd;
    @(posedge clk);
    sbq.push_back(it);
  endtask

  // monitor: compares outputs half a cycle after the edge that produced them
  initial begin
    forever begin
      @(negedge clk);
      if (sbq.size() > 0) begin
        item_t it;
        it = sbq.pop_front();
        check(it.req, "rdDataA", rdDataA, it.expA);
        check(it.req, "rdDataB", rdDataB, it.expB);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = '0;
    rdAddrA = 5'd3; rdAddrB = 5'd9;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "rdDataA in reset", rdDataA, 32'h0);
    check("R1", "rdDataB in reset", rdDataB, 32'h0);
    rstN = 1'b1;

    // R1: every entry zero after reset, R7 different addresses per port
    for (int i = 0; i < 16; i++)
      drive(5'(i), 5'(31 - i), 1'b0, 5'd0, 32'h0, "R1");

    // R3: fill registers, read unrelated ones meanwhile
    for (int i = 1; i < 32; i++)
      drive(5'((i + 7) % 32), 5'((i + 13) % 32), 1'b1, 5'(i),
            32'hA500_0000 + 32'(i * 32'h0101), "R3");
    for (int i = 1; i < 32; i += 2)
      drive(5'(i), 5'(i + 1), 1'b0, 5'd0, 32'h0, "R7");

    // R3: enable low must not change register 5
    drive(5'd1, 5'd2, 1'b0, 5'd5, 32'hDEAD_BEEF, "R3");
    drive(5'd5, 5'd6, 1'b0, 5'd0, 32'h0, "R3");

    // R4 and R6: both ports read the register being written
    drive(5'd7, 5'd7, 1'b1, 5'd7, 32'h1234_5678, "R4");
    drive(5'd7, 5'd7, 1'b0, 5'd0, 32'h0, "R6");
    // R4: only port B collides, port A reads another entry
    drive(5'd9, 5'd12, 1'b1, 5'd12, 32'hCAFE_0012, "R4");
    // R4: only port A collides
    drive(5'd20, 5'd9, 1'b1, 5'd20, 32'h0BAD_F00D, "R4");
    // R2: back-to-back writes, each read follows its own edge
    drive(5'd20, 5'd20, 1'b1, 5'd20, 32'h1111_1111, "R2");
    drive(5'd20, 5'd20, 1'b1, 5'd20, 32'h2222_2222, "R2");
    drive(5'd20, 5'd21, 1'b0, 5'd0, 32'h0, "R2");

    // R5: write to register zero while reading it
    drive(5'd0, 5'd0, 1'b1, 5'd0, 32'hFFFF_FFFF, "R5");
    drive(5'd0, 5'd1, 1'b0, 5'd0, 32'h0, "R5");

    // random run over a narrow address range to force collisions
    for (int n = 0; n < 300; n++) begin
      logic [4:0] a, b, w;
      logic       we;
      string      tag;
      a  = 5'($urandom_range(0, 5));
      b  = 5'($urandom_range(0, 5));
      w  = 5'($urandom_range(0, 5));
      we = 1'($urandom_range(0, 1));
      if (a == 5'd0 || b == 5'd0) tag = "R5";
      else if (we && (w == a || w == b)) tag = "R4";
      else if (a == b) tag = "R6";
      else tag = "R3";
      drive(a, b, we, w, $urandom, tag);
    end

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule